// File: doc/BRIEF.md
# Bit-sliced ALU with flags

This block is a purely combinational arithmetic and logic unit built from a chain of identical one-bit slices. Each slice forms the AND and OR of its operand bits and has a full adder. A small selector in the slice picks which of these values becomes the slice's result bit. The adder carries ripple from bit 0 upward. A 3-bit operation code selects bitwise AND, bitwise OR, addition, subtraction or set-on-less-than.

Subtraction reuses the adder. The top bit of the operation code inverts operand B in every slice and also feeds the carry into bit 0, so the chain computes A plus the complement of B plus one. Only the top slice carries extra logic. It exports its raw sum bit as the "less" line, which set-on-less-than routes back into result bit 0. It also exports the XOR of its carry in and carry out as the overflow line.

A zero flag reports an all-zero result. A carry flag reports the adder's final carry-out. The block has no clock and no state. A result is valid as soon as the ripple chain settles within the cycle that consumes it.

Top module: `bitslice_alu`

## Requirements
- R1: Operation code 3'b000 gives result = A AND B, bit by bit.
- R2: Operation code 3'b001 gives result = A OR B, bit by bit.
- R3: Operation code 3'b010 gives result = (A + B) mod 2^WIDTH. carry_o is the carry out of the top bit of that sum.
- R4: Operation code 3'b110 gives result = (A + ~B + 1) mod 2^WIDTH, that is, A − B. carry_o is the carry out of the top bit of that sum, so it is 1 exactly when A ≥ B read as unsigned numbers.
- R5: Operation code 3'b111 puts the top bit of the raw difference A + ~B + 1 into result bit 0 and clears every other result bit. carry_o is that difference's carry-out. The sign is not corrected for overflow, so 0x80000000 against 1 yields 0.
- R6: For add and subtract, overflow_o is 1 exactly when the signed result is out of range. For add, that means both operands have the same sign and the result sign differs from it. For subtract, it means the operand signs differ and the result sign differs from A's sign.
- R7: For AND, OR, set-on-less-than and the unused operation codes, overflow_o is 0.
- R8: The unused operation codes 3'b011, 3'b100 and 3'b101 give a result of all zeros, overflow_o = 0 and carry_o = 0.
- R9: zero_o is 1 exactly when every bit of result_o is 0, under every operation code.
- R10: The operand width is the parameter WIDTH (default 32, at least 2). A 4-bit instance obeys R1 to R9 with 4 in place of 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 3 | Operation code |
| result_o | output | WIDTH | Selected result |
| zero_o | output | 1 | High when the result is all zeros |
| overflow_o | output | 1 | Signed overflow of add or subtract |
| carry_o | output | 1 | Adder carry-out for add, subtract and set-on-less-than |

## Verification
The block holds no registers. A wrong internal value is therefore a broken slice, a miswired carry link or a wrong decode, and it shows at the ports in the same cycle as the operands that expose it. A bad carry link corrupts every result bit above it once a carry has to cross that link. The bench therefore sweeps every operand pair and every operation code on a 4-bit instance, which reaches every carry pattern. A bad top slice shows up first in overflow_o and in set-on-less-than. The 32-bit instance is checked at the sign-boundary corner values and with random operands.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        PICK_AND  = 2'b00,
        PICK_OR   = 2'b01,
        PICK_SUM  = 2'b10,
        PICK_LESS = 2'b11
    } pick_e;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [2:0] op_i,
    output logic       invert_b_o,
    output pick_e      pick_o,
    output logic       arith_o,
    output logic       slt_o,
    output logic       legal_o
);

    always_comb begin
        invert_b_o = 1'b0;
        pick_o     = PICK_AND;
        arith_o    = 1'b0;
        slt_o      = 1'b0;
        legal_o    = 1'b1;
        unique case (op_i)
            OP_AND: pick_o = PICK_AND;
            OP_OR:  pick_o = PICK_OR;
            OP_ADD: begin
                pick_o  = PICK_SUM;
                arith_o = 1'b1;
            end
            OP_SUB: begin
                pick_o     = PICK_SUM;
                invert_b_o = 1'b1;
                arith_o    = 1'b1;
            end
            OP_SLT: begin
                pick_o     = PICK_LESS;
                invert_b_o = 1'b1;
                slt_o      = 1'b1;
            end
            default: legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
#(
    parameter bit IS_MSB = 1'b0
) (
    input  logic  a_i,
    input  logic  b_i,
    input  logic  invert_i,
    input  logic  cin_i,
    input  logic  less_i,
    input  pick_e pick_i,
    output logic  res_o,
    output logic  cout_o,
    output logic  set_o,
    output logic  ovf_o
);

    logic b_eff;
    logic sum_w;

    assign b_eff  = b_i ^ invert_i;
    assign sum_w  = a_i ^ b_eff ^ cin_i;
    assign cout_o = (b_eff & cin_i) | (a_i & cin_i) | (a_i & b_eff);

    always_comb begin
        unique case (pick_i)
            PICK_AND:  res_o = a_i & b_eff;
            PICK_OR:   res_o = a_i | b_eff;
            PICK_SUM:  res_o = sum_w;
            PICK_LESS: res_o = less_i;
            default:   res_o = 1'b0;
        endcase
    end

    generate
        if (IS_MSB) begin : g_msb
            assign set_o = sum_w;
            assign ovf_o = cin_i ^ cout_o;
        end else begin : g_plain
            assign set_o = 1'b0;
            assign ovf_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value_i,
    output logic             zero_o
);

    assign zero_o = ~|value_i;

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [2:0]       op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             overflow_o,
    output logic             carry_o
);

    localparam int MSB = WIDTH - 1;

    logic             invert_b;
    pick_e            pick;
    logic             arith;
    logic             slt;
    logic             legal;
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] raw_res;
    logic [WIDTH-1:0] set_v;
    logic [WIDTH-1:0] ovf_v;
    logic [WIDTH-1:0] less_v;
    logic             set_line;
    logic             ovf_line;

    alu_decode u_decode (
        .op_i       (op_i),
        .invert_b_o (invert_b),
        .pick_o     (pick),
        .arith_o    (arith),
        .slt_o      (slt),
        .legal_o    (legal)
    );

    assign carry[0] = invert_b;
    assign set_line = |set_v;
    assign ovf_line = |ovf_v;
    assign less_v   = {{(WIDTH-1){1'b0}}, set_line};

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_slice
            alu_slice #(
                .IS_MSB (i == MSB)
            ) u_slice (
                .a_i      (a_i[i]),
                .b_i      (b_i[i]),
                .invert_i (invert_b),
                .cin_i    (carry[i]),
                .less_i   (less_v[i]),
                .pick_i   (pick),
                .res_o    (raw_res[i]),
                .cout_o   (carry[i+1]),
                .set_o    (set_v[i]),
                .ovf_o    (ovf_v[i])
            );
        end
    endgenerate

    assign result_o   = legal ? raw_res : '0;
    assign overflow_o = arith & ovf_line;
    assign carry_o    = (arith | slt) & carry[WIDTH];

    alu_zero_detect #(
        .WIDTH (WIDTH)
    ) u_zero (
        .value_i (result_o),
        .zero_o  (zero_o)
    );

    always_comb begin
        if (!$isunknown({a_i, b_i, op_i})) begin
            a_r9_zero_flag: assert (zero_o == (result_o == '0))
                else $error("R9 zero flag disagrees with result");
            if (op_i == OP_ADD) begin
                a_r3_add_sum: assert (result_o == a_i + b_i)
                    else $error("R3 sum wrong");
                a_r6_add_overflow: assert (overflow_o ==
                    ((a_i[MSB] == b_i[MSB]) && (result_o[MSB] != a_i[MSB])))
                    else $error("R6 add overflow wrong");
            end
            if (op_i == OP_SUB) begin
                a_r4_sub_diff: assert (result_o == a_i - b_i)
                    else $error("R4 difference wrong");
                a_r6_sub_overflow: assert (overflow_o ==
                    ((a_i[MSB] != b_i[MSB]) && (result_o[MSB] != a_i[MSB])))
                    else $error("R6 subtract overflow wrong");
            end
            if (op_i == OP_SLT) begin
                a_r5_slt_upper_clear: assert (result_o[WIDTH-1:1] == '0)
                    else $error("R5 upper bits not cleared");
            end
            if (op_i != OP_ADD && op_i != OP_SUB) begin
                a_r7_no_overflow: assert (!overflow_o)
                    else $error("R7 overflow outside add/subtract");
            end
            if (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101) begin
                a_r8_unused_quiet: assert (result_o == '0 && !carry_o)
                    else $error("R8 unused code not quiet");
            end
        end
    end

endmodule

// File: tb/bitslice_alu_test.sv
`timescale 1ns/1ps
module bitslice_alu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    logic [31:0] a32 = '0, b32 = '0;
    logic [2:0]  op32 = '0;
    logic [31:0] r32;
    logic        z32, ov32, c32;

    logic [3:0]  a4 = '0, b4 = '0;
    logic [2:0]  op4 = '0;
    logic [3:0]  r4;
    logic        z4, ov4, c4;

    always #4 clk = ~clk;

    bitslice_alu #(.WIDTH(32)) uut (
        .a_i(a32), .b_i(b32), .op_i(op32),
        .result_o(r32), .zero_o(z32), .overflow_o(ov32), .carry_o(c32)
    );

    bitslice_alu #(.WIDTH(4)) uut_small (
        .a_i(a4), .b_i(b4), .op_i(op4),
        .result_o(r4), .zero_o(z4), .overflow_o(ov4), .carry_o(c4)
    );

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b110:  return "R4";
            3'b111:  return "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic model(input int w, input logic [31:0] a, input logic [31:0] b,
                         input logic [2:0] op, output logic [31:0] r,
                         output logic z, output logic ov, output logic co);
        logic [31:0] m;
        logic [32:0] s;
        m  = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        r  = '0;
        ov = 1'b0;
        co = 1'b0;
        case (op)
            3'b000: r = a & b;
            3'b001: r = a | b;
            3'b010: begin
                s  = {1'b0, a} + {1'b0, b};
                r  = s[31:0] & m;
                co = s[w];
                ov = (a[w-1] == b[w-1]) && (r[w-1] != a[w-1]);
            end
            3'b110: begin
                s  = {1'b0, a} + {1'b0, (~b) & m} + 33'd1;
                r  = s[31:0] & m;
                co = s[w];
                ov = (a[w-1] != b[w-1]) && (r[w-1] != a[w-1]);
            end
            3'b111: begin
                s  = {1'b0, a} + {1'b0, (~b) & m} + 33'd1;
                r  = {31'd0, s[w-1]};
                co = s[w];
            end
            default: r = '0;
        endcase
        z = (r == '0);
    endtask

    task automatic compare(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run32(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
        logic [31:0] er;
        logic ez, eov, ec;
        @(posedge clk);
        a32 = a; b32 = b; op32 = op;
        @(negedge clk);
        model(32, a, b, op, er, ez, eov, ec);
        compare(op_tag(op), "result", r32, er);
        compare((op == 3'b010 || op == 3'b110) ? "R6" : "R7", "overflow", {31'd0, ov32}, {31'd0, eov});
        compare("R9", "zero", {31'd0, z32}, {31'd0, ez});
        compare(op_tag(op), "carry", {31'd0, c32}, {31'd0, ec});
    endtask

    task automatic run4(input logic [3:0] a, input logic [3:0] b, input logic [2:0] op);
        logic [31:0] er;
        logic ez, eov, ec;
        @(posedge clk);
        a4 = a; b4 = b; op4 = op;
        @(negedge clk);
        model(4, {28'd0, a}, {28'd0, b}, op, er, ez, eov, ec);
        compare({"R10 ", op_tag(op)}, "result", {28'd0, r4}, er);
        compare("R10 overflow", "overflow", {31'd0, ov4}, {31'd0, eov});
        compare("R10 zero", "zero", {31'd0, z4}, {31'd0, ez});
        compare({"R10 ", op_tag(op)}, "carry", {31'd0, c4}, {31'd0, ec});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stimulus
        logic [31:0] ra, rb;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset-time state: zero operands with AND give an all-zero result (R1, R9)
        compare("R1", "reset result", r32, 32'd0);
        compare("R9", "reset zero", {31'd0, z32}, 32'd1);
        rst_n = 1'b1;

        // corner cases at the sign boundary
        run32(32'h7FFF_FFFF, 32'h0000_0001, 3'b010);   // R3/R6 positive overflow
        run32(32'h8000_0000, 32'h0000_0001, 3'b110);   // R4/R6 negative overflow
        run32(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);   // R3 carry out, zero result
        run32(32'h1234_5678, 32'h1234_5678, 3'b110);   // R4 equal operands, zero
        run32(32'h1234_5678, 32'h1234_5678, 3'b111);   // R5 equal operands give 0
        run32(32'h0000_0001, 32'h0000_0002, 3'b111);   // R5 less than gives 1
        run32(32'h8000_0000, 32'h0000_0001, 3'b111);   // R5 raw sign, no correction
        run32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011);   // R8 unused code
        run32(32'hFFFF_FFFF, 32'h0000_0000, 3'b100);   // R8 unused code
        run32(32'hA5A5_A5A5, 32'h5A5A_5A5A, 3'b101);   // R8 unused code
        run32(32'hF0F0_F0F0, 32'h0F0F_0F0F, 3'b000);   // R1 disjoint bits
        run32(32'hF0F0_F0F0, 32'h0F0F_0F0F, 3'b001);   // R2 fills all bits

        // exhaustive sweep of the 4-bit instance (R10)
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    run4(4'(a), 4'(b), 3'(op));

        // random operands on the 32-bit instance, every code
        void'($urandom(32'd1357));
        for (int n = 0; n < 1500; n++) begin
            ra = $urandom();
            rb = $urandom();
            for (int op = 0; op < 8; op++)
                run32(ra, rb, 3'(op));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule